// File: doc/BRIEF.md
# Two-Floor Elevator Controller

This block is the sequencing core of a lift that serves two floors. It is a six-state machine, and the state register is coded so that its three bits are the door, motion and direction commands themselves. No output decoder sits between the register and those pins.

The inputs are a hall call button on each floor, a floor-select button for each floor inside the car, and a door-open button. A one-cycle arrival pulse comes from the floor sensor. Each button feeds its own capture flag, so a press sampled on one clock edge is held until the request has been served. A door-dwell counter, set by a parameter, closes the door when no request comes in time. The block also gives a current-floor number for display. The direction output doubles as the direction shown on the display.

Top module: `lift2_ctrl`

## Requirements
- R1: The state code is {door_closed_o, moving_o, dir_down_o}, with door 1 = closed, motion 1 = moving and direction 1 = down. The codes are: open at floor 1 = 000, closed at floor 1 = 100, moving up = 110, open at floor 2 = 001, closed at floor 2 = 101, moving down = 111. A door that is open never comes with motion.
- R2: While rst_n is low, and after it is released, the block is in the open-at-floor-1 state (000) with floor_o = 1.
- R3: In an open state with no request, the door closes exactly DWELL_CYCLES clock edges after the counter was last loaded. Entering an open state loads the counter, and so does the release of reset.
- R4: An open-door request seen in an open state reloads the dwell counter, which keeps the door open longer.
- R5: In a closed state, an open-door request or a hall call on the same floor reopens the door. This takes priority over a request for the other floor, which stays pending.
- R6: A hall call or car button for the other floor moves the machine from the open or closed state to moving up (from floor 1) or moving down (from floor 2).
- R7: A moving state is held until arrive_i is high at an edge. Moving up then goes to open at floor 2, and moving down goes to open at floor 1. arrive_i has no effect in any other state.
- R8: A button that is high at one clock edge sets its capture flag. The flag is held until the machine enters the state the request asks for. The machine acts on a captured request at the following edge, so a press changes the state two edges after it is sampled.
- R9: floor_o is 1 in the open-at-1, closed-at-1 and moving-up states, and 2 in the open-at-2, closed-at-2 and moving-down states. It therefore shows the floor of departure while the car is moving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall1_btn_i | input | 1 | Hall call button, floor 1 |
| hall2_btn_i | input | 1 | Hall call button, floor 2 |
| car1_btn_i | input | 1 | In-car floor-1 button |
| car2_btn_i | input | 1 | In-car floor-2 button |
| open_btn_i | input | 1 | In-car door-open button |
| arrive_i | input | 1 | Floor sensor arrival pulse |
| door_closed_o | output | 1 | 1 = door closed |
| moving_o | output | 1 | 1 = car moving |
| dir_down_o | output | 1 | 1 = direction down |
| floor_o | output | 2 | Current floor number (1 or 2) |

## Verification
A button press changes the state two edges after it is sampled: one edge to set the flag and one for the machine to act on it. The arrival pulse acts at the edge where it is sampled. A dwell timeout lands DWELL_CYCLES edges after the last load. The bench drives every input at a falling edge and holds it for exactly one rising edge. It checks the outputs at the next falling edge, and it checks the intermediate states along the way, so an early or late transition shows up as a mismatch. The expected codes come from the state-code table in R1, and the expected floor comes from R9.

// File: rtl/lift2_pkg.sv
package lift2_pkg;
   typedef enum logic [2:0] {
      ST_OPEN1  = 3'b000,
      ST_SHUT1  = 3'b100,
      ST_RISE   = 3'b110,
      ST_OPEN2  = 3'b001,
      ST_SHUT2  = 3'b101,
      ST_FALL   = 3'b111
   } lift_st_e;

   localparam int BTN_HALL1 = 0;
   localparam int BTN_HALL2 = 1;
   localparam int BTN_CAR1  = 2;
   localparam int BTN_CAR2  = 3;
   localparam int BTN_OPEN  = 4;
   localparam int N_BTN     = 5;
endpackage

// File: rtl/lift2_capture.sv
module lift2_capture #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] btn_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   generate
      if (N < 1) begin : g_bad
         $error("lift2_capture: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_flag
         logic held_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        held_q <= 1'b0;
            else if (btn_i[i]) held_q <= 1'b1;
            else if (clr_i[i]) held_q <= 1'b0;
         end
         assign flag_o[i] = held_q;

         // R8
         hold_until_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (held_q && !clr_i[i]) |=> held_q);
      end
   endgenerate
endmodule

// File: rtl/lift2_dwell.sv
module lift2_dwell #(
   parameter int DWELL_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic expired_o
);
   localparam int CNT_W = (DWELL_CYCLES > 2) ? $clog2(DWELL_CYCLES) : 1;
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DWELL_CYCLES - 1);

   generate
      if (DWELL_CYCLES < 2) begin : g_bad
         $error("lift2_dwell: DWELL_CYCLES must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= RELOAD;
      else if (load_i)         cnt_q <= RELOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);

   // R4
   reload_not_expired_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !expired_o);
endmodule

// File: rtl/lift2_fsm.sv
module lift2_fsm
   import lift2_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_BTN-1:0] req_i,
   input  logic             arrive_i,
   input  logic             expired_i,
   output lift_st_e         state_o,
   output logic             load_o,
   output logic [N_BTN-1:0] clr_o
);
   lift_st_e state_q, state_d;

   logic want1, want2, open_req;
   assign want1    = req_i[BTN_HALL1] | req_i[BTN_CAR1];
   assign want2    = req_i[BTN_HALL2] | req_i[BTN_CAR2];
   assign open_req = req_i[BTN_OPEN];

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_OPEN1: if (want2)                       state_d = ST_RISE;
                   else if (expired_i && !open_req) state_d = ST_SHUT1;
         ST_SHUT1: if (open_req || req_i[BTN_HALL1]) state_d = ST_OPEN1;
                   else if (want2)                   state_d = ST_RISE;
         ST_RISE:  if (arrive_i)                     state_d = ST_OPEN2;
         ST_OPEN2: if (want1)                        state_d = ST_FALL;
                   else if (expired_i && !open_req)  state_d = ST_SHUT2;
         ST_SHUT2: if (open_req || req_i[BTN_HALL2]) state_d = ST_OPEN2;
                   else if (want1)                   state_d = ST_FALL;
         ST_FALL:  if (arrive_i)                     state_d = ST_OPEN1;
         default:                                    state_d = ST_OPEN1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_OPEN1;
      else        state_q <= state_d;
   end

   logic next_open1, next_open2;
   assign next_open1 = (state_d == ST_OPEN1);
   assign next_open2 = (state_d == ST_OPEN2);

   assign load_o = (next_open1 || next_open2) && ((state_d != state_q) || open_req);

   always_comb begin
      clr_o            = '0;
      clr_o[BTN_HALL1] = next_open1;
      clr_o[BTN_CAR1]  = next_open1;
      clr_o[BTN_HALL2] = next_open2;
      clr_o[BTN_CAR2]  = next_open2;
      clr_o[BTN_OPEN]  = next_open1 || next_open2;
   end

   assign state_o = state_q;

   // R1
   door_open_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !state_q[2] |-> !state_q[1]);
   // R7
   rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RISE && !arrive_i) |=> state_q == ST_RISE);
   // R7
   rise_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RISE && arrive_i) |=> state_q == ST_OPEN2);
   // R5
   shut1_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SHUT1 && open_req) |=> state_q == ST_OPEN1);
   // R6
   open2_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OPEN2 && want1) |=> state_q == ST_FALL);
endmodule

// File: rtl/lift2_ctrl.sv
module lift2_ctrl
   import lift2_pkg::*;
#(
   parameter int DWELL_CYCLES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hall1_btn_i,
   input  logic       hall2_btn_i,
   input  logic       car1_btn_i,
   input  logic       car2_btn_i,
   input  logic       open_btn_i,
   input  logic       arrive_i,
   output logic       door_closed_o,
   output logic       moving_o,
   output logic       dir_down_o,
   output logic [1:0] floor_o
);
   logic [N_BTN-1:0] btn, clr, req;
   logic             load, expired;
   lift_st_e         state;

   always_comb begin
      btn            = '0;
      btn[BTN_HALL1] = hall1_btn_i;
      btn[BTN_HALL2] = hall2_btn_i;
      btn[BTN_CAR1]  = car1_btn_i;
      btn[BTN_CAR2]  = car2_btn_i;
      btn[BTN_OPEN]  = open_btn_i;
   end

   lift2_capture #(.N(N_BTN)) i_capture (
      .clk(clk), .rst_n(rst_n), .btn_i(btn), .clr_i(clr), .flag_o(req)
   );

   lift2_dwell #(.DWELL_CYCLES(DWELL_CYCLES)) i_dwell (
      .clk(clk), .rst_n(rst_n), .load_i(load), .expired_o(expired)
   );

   lift2_fsm i_fsm (
      .clk(clk), .rst_n(rst_n), .req_i(req), .arrive_i(arrive_i),
      .expired_i(expired), .state_o(state), .load_o(load), .clr_o(clr)
   );

   assign door_closed_o = state[2];
   assign moving_o      = state[1];
   assign dir_down_o    = state[0];
   assign floor_o       = state[0] ? 2'd2 : 2'd1;
endmodule

// File: tb/test_lift2_ctrl.sv
module test_lift2_ctrl;
   localparam int DW = 4;
   localparam logic [2:0] S_O1 = 3'b000, S_C1 = 3'b100, S_UP = 3'b110,
                          S_O2 = 3'b001, S_C2 = 3'b101, S_DN = 3'b111;
   // button vector order {open, car2, car1, hall2, hall1}
   localparam logic [4:0] B_NONE = 5'b00000, B_H1 = 5'b00001, B_H2 = 5'b00010,
                          B_K1 = 5'b00100, B_K2 = 5'b01000, B_OP = 5'b10000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic h1 = 0, h2 = 0, k1 = 0, k2 = 0, op = 0, arr = 0;
   logic door, mov, dir;
   logic [1:0] flr;
   int checks = 0, fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   lift2_ctrl #(.DWELL_CYCLES(DW)) i_lift2_ctrl (
      .clk(clk), .rst_n(rst_n), .hall1_btn_i(h1), .hall2_btn_i(h2),
      .car1_btn_i(k1), .car2_btn_i(k2), .open_btn_i(op), .arrive_i(arr),
      .door_closed_o(door), .moving_o(mov), .dir_down_o(dir), .floor_o(flr)
   );

   task automatic chk(input logic [2:0] exp, input string req);
      logic [4:0] act, want;
      act  = {door, mov, dir, flr};
      want = {exp, (exp[0] ? 2'd2 : 2'd1)};
      checks++;
      if (act !== want) begin
         fails++;
         $display("FAIL %s: got state/floor %b/%0d expected %b/%0d",
                  req, act[4:2], act[1:0], want[4:2], want[1:0]);
      end
   endtask

   task automatic tick(input logic [4:0] b, input logic a);
      {op, k2, k1, h2, h1} = b;
      arr = a;
      @(posedge clk);
      @(negedge clk);
      {op, k2, k1, h2, h1} = '0;
      arr = 1'b0;
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got hung run expected completion");
         report();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(S_O1, "R2 during reset");
      rst_n = 1'b1;
      chk(S_O1, "R2 after release");
      // R3: dwell from reset release
      for (int i = 0; i < DW - 1; i++) begin
         tick(B_NONE, 0);
         chk(S_O1, "R3 door held open");
      end
      tick(B_NONE, 0);
      chk(S_C1, "R3 door closes on dwell");
      // R7: arrive ignored when not moving
      tick(B_NONE, 1);
      chk(S_C1, "R7 arrive ignored in closed state");
      // R5 / R8: open in closed state, two-edge latency
      tick(B_OP, 0);
      chk(S_C1, "R8 press not acted on at sampling edge");
      tick(B_NONE, 0);
      chk(S_O1, "R5 open reopens door");
      // R4: open during wait extends dwell
      tick(B_NONE, 0);
      tick(B_OP, 0);
      for (int i = 0; i < DW; i++) begin
         tick(B_NONE, 0);
         chk(S_O1, "R4 dwell extended by open");
      end
      tick(B_NONE, 0);
      chk(S_C1, "R4 closes after extended dwell");
      // R5: same-floor wins, R8: other-floor held
      tick(B_H1 | B_H2, 0);
      tick(B_NONE, 0);
      chk(S_O1, "R5 same-floor call wins");
      tick(B_NONE, 0);
      chk(S_UP, "R8 held floor-2 call then served");
      // R7: moving holds, R8: car1 captured while moving
      tick(B_K1, 0);
      chk(S_UP, "R7 rise held without arrive");
      tick(B_NONE, 0);
      chk(S_UP, "R7 rise held without arrive");
      tick(B_NONE, 1);
      chk(S_O2, "R7 arrive ends rise at floor 2");
      tick(B_NONE, 0);
      chk(S_DN, "R8 car1 captured during rise");
      tick(B_NONE, 0);
      chk(S_DN, "R9 floor of departure while falling");
      tick(B_NONE, 1);
      chk(S_O1, "R7 arrive ends fall at floor 1");
      // R6: car2 from open-at-1
      tick(B_K2, 0);
      tick(B_NONE, 0);
      chk(S_UP, "R6 car2 sends car up");
      tick(B_NONE, 1);
      chk(S_O2, "R7 arrive at floor 2");
      for (int i = 0; i < DW - 1; i++) begin
         tick(B_NONE, 0);
         chk(S_O2, "R3 floor-2 door held open");
      end
      tick(B_NONE, 0);
      chk(S_C2, "R3 floor-2 dwell closes door");
      tick(B_H2, 0);
      tick(B_NONE, 0);
      chk(S_O2, "R5 floor-2 hall call reopens");
      for (int i = 0; i < DW - 1; i++) tick(B_NONE, 0);
      chk(S_O2, "R3 reload on reopen");
      tick(B_NONE, 0);
      chk(S_C2, "R3 closes again");
      tick(B_K1, 0);
      tick(B_NONE, 0);
      chk(S_DN, "R6 car1 from closed-at-2");
      tick(B_NONE, 1);
      chk(S_O1, "R1 back to open at floor 1");
      // R6: hall2 from closed-at-1
      for (int i = 0; i < DW; i++) tick(B_NONE, 0);
      chk(S_C1, "R3 closed at floor 1");
      tick(B_H2, 0);
      tick(B_NONE, 0);
      chk(S_UP, "R6 hall2 from closed-at-1");
      done = 1;
      report();
      $finish;
   end
endmodule